// File: doc/BRIEF.md
# Passive JTAG Bus Sniffer

This block listens to a four-wire JTAG port (clock, mode select, data in, data out) that some other master drives. It never drives those wires. All four lines are brought into the system clock domain through synchronizers. Each rising edge of the test clock is turned into a single capture event. From the mode-select values seen at those events the block rebuilds the state of the target's test access port controller.

While the rebuilt controller sits in one of the two shift states, the serial bits on the data-in and data-out wires are packed into bytes. Each byte becomes one tagged record in a circular buffer. A record holds the register kind, the data-in byte, the data-out byte and the number of valid bits. A downstream consumer, typically a serial transmitter, drains the records through a valid/ready read port. The consumer may hold `rd_ready` low for as long as it likes. Records wait in the buffer until the buffer fills. After that, new records are discarded and a sticky flag reports the loss.

Top module: `jtag_sniffer`

## Requirements
- R1: The three data lines are captured together, once per rising edge of `jtag_tck` after synchronization. Changes of `jtag_tms`, `jtag_tdi` or `jtag_tdo` while `jtag_tck` stays level have no effect on `tap_state` or on the buffer.
- R2: After reset `tap_state` reads 0 (Test-Logic-Reset), `rd_valid` is 0, `fill_level` is 0 and `overflow` is 0. The `tap_state` codes are: 0 test-logic-reset, 1 run-test/idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR.
- R3: At each capture the tracked state moves along the full sixteen-state IEEE 1149.1 controller graph, steered by the captured mode-select value. This includes the pause and exit2 branches back into shift.
- R4: Five consecutive captures with mode-select high leave `tap_state` at 0, whatever the starting state.
- R5: A capture taken in shift-DR or shift-IR stores the data-in and data-out bits least significant bit first, in wire order. The eighth bit completes a record with `rd_nbits` = 8. `rd_is_ir` is 1 for shift-IR and 0 for shift-DR.
- R6: A capture taken in a shift state with mode-select high flushes the partly filled byte as a record. Its `rd_nbits` equals the number of bits collected (1 to 8), and its unused upper bits are 0. Captures in any non-shift state add no record.
- R7: A pass through pause and exit2 back into shift starts a fresh byte. The bits before the pause were already flushed on the way out through exit1.
- R8: `rd_valid` is 1 exactly when `fill_level` is non-zero. The fields of the oldest record stay stable while `rd_valid` is 1 and `rd_ready` is 0. A record is removed on a cycle where both are 1. Records come out in the order they were made.
- R9: A record produced while `fill_level` equals the buffer depth is dropped and sets `overflow`. `overflow` stays set until `ovf_clear` is pulsed. A new loss in the same cycle as the clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the test clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| jtag_tck | input | 1 | Observed test clock |
| jtag_tms | input | 1 | Observed mode select |
| jtag_tdi | input | 1 | Observed serial data into the target |
| jtag_tdo | input | 1 | Observed serial data out of the target |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| rd_valid | output | 1 | A record is available |
| rd_ready | input | 1 | Consumer accepts the record |
| rd_is_ir | output | 1 | 1 for an instruction-register record, 0 for a data-register record |
| rd_tdi | output | 8 | Data-in byte, first bit in bit 0 |
| rd_tdo | output | 8 | Data-out byte, first bit in bit 0 |
| rd_nbits | output | 4 | Number of valid bits, 1 to 8 |
| fill_level | output | 5 | Records currently held |
| overflow | output | 1 | Sticky record-loss flag |
| tap_state | output | 4 | Tracked controller state code |

## Verification
The assertions check, on every cycle, the rules that need only a short look at the signals. A capture event is never two cycles long. Five high mode-select captures always land in test-logic-reset. Every record carries a bit count from 1 to 8. The fill level never exceeds the depth. The oldest record holds still under back-pressure. The overflow flag stays set until cleared and is raised by a write into a full buffer. The bench scenarios are needed for the rest: the exact path taken through the state graph, the bit order and contents of full and flushed bytes, the lack of records from pause states, and record order after an overflow.

// File: rtl/jsnf_pkg.sv
package jsnf_pkg;
  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,  ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,  ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,  ST_EX1_DR = 4'd5,
    ST_PA_DR  = 4'd6,  ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,  ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10, ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12, ST_PA_IR  = 4'd13,
    ST_EX2_IR = 4'd14, ST_UPD_IR = 4'd15
  } tap_st_t;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef struct packed {
    logic              is_ir;
    logic [BYTE_W-1:0] tdi;
    logic [BYTE_W-1:0] tdo;
    logic [CNT_W-1:0]  nbits;
  } cap_rec_t;

  localparam int REC_W = $bits(cap_rec_t);
endpackage

// File: rtl/jsnf_pin_sync.sv
module jsnf_pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] pins_o,
  output logic         tck_rise_o
);
  logic [W-1:0] stg [STAGES];
  logic         tck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      tck_prev <= 1'b0;
    end else begin
      stg[0] <= pins_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      tck_prev <= stg[STAGES-1][0];
    end
  end

  assign pins_o     = stg[STAGES-1];
  assign tck_rise_o = pins_o[0] & ~tck_prev;

  // R1: one capture per clock edge, never a two-cycle event
  p_single_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tck_rise_o |=> !tck_rise_o);
endmodule

// File: rtl/jsnf_tap_tracker.sv
module jsnf_tap_tracker
  import jsnf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cap_i,
  input  logic    tms_i,
  output tap_st_t state_o
);
  tap_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_TLR:    st_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    st_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: st_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: st_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  st_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: st_d = tms_i ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  st_d = tms_i ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: st_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: st_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: st_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: st_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  st_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: st_d = tms_i ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  st_d = tms_i ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: st_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: st_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   st_d = ST_TLR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_TLR;
    else if (cap_i) st_q <= st_d;
  end

  assign state_o = st_q;

  // Run length of high mode-select captures, saturating at 5
  logic [2:0] ones_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ones_q <= 3'd0;
    else if (cap_i) ones_q <= !tms_i ? 3'd0 : (ones_q == 3'd5 ? 3'd5 : ones_q + 3'd1);
  end

  p_five_ones_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q == 3'd5) |-> (st_q == ST_TLR));
  p_hold_between_caps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(st_q));
endmodule

// File: rtl/jsnf_byte_packer.sv
module jsnf_byte_packer
  import jsnf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cap_i,
  input  logic     tms_i,
  input  logic     tdi_i,
  input  logic     tdo_i,
  input  tap_st_t  state_i,
  output logic     wr_o,
  output cap_rec_t rec_o
);
  localparam int IDX_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q, cnt_inc;
  logic [BYTE_W-1:0] acc_tdi_q, acc_tdo_q, nxt_tdi, nxt_tdo;
  logic              in_shift;

  always_comb begin
    in_shift = (state_i == ST_SH_DR) || (state_i == ST_SH_IR);
    cnt_inc  = cnt_q + CNT_W'(1);
    nxt_tdi  = acc_tdi_q;
    nxt_tdo  = acc_tdo_q;
    nxt_tdi[cnt_q[IDX_W-1:0]] = tdi_i;
    nxt_tdo[cnt_q[IDX_W-1:0]] = tdo_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      acc_tdi_q <= '0;
      acc_tdo_q <= '0;
      wr_o      <= 1'b0;
      rec_o     <= '0;
    end else begin
      wr_o <= 1'b0;
      if (cap_i) begin
        if (in_shift && (tms_i || cnt_inc == CNT_W'(BYTE_W))) begin
          wr_o      <= 1'b1;
          rec_o     <= '{is_ir: (state_i == ST_SH_IR), tdi: nxt_tdi,
                         tdo: nxt_tdo, nbits: cnt_inc};
          cnt_q     <= '0;
          acc_tdi_q <= '0;
          acc_tdo_q <= '0;
        end else if (in_shift) begin
          cnt_q     <= cnt_inc;
          acc_tdi_q <= nxt_tdi;
          acc_tdo_q <= nxt_tdo;
        end else begin
          cnt_q     <= '0;
          acc_tdi_q <= '0;
          acc_tdo_q <= '0;
        end
      end
    end
  end

  // R5/R6: every record carries between 1 and 8 bits
  p_rec_bits_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (rec_o.nbits >= CNT_W'(1) && rec_o.nbits <= CNT_W'(BYTE_W)));
  // R6: records only follow a capture taken in a shift state
  p_rec_from_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && !in_shift) |=> !wr_o);
endmodule

// File: rtl/jsnf_ring_buf.sv
module jsnf_ring_buf #(
  parameter int W     = 21,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic [W-1:0]               wdata_i,
  output logic                       rd_valid_o,
  input  logic                       rd_ready_i,
  output logic [W-1:0]               rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  input  logic                       ovf_clear_i,
  output logic                       overflow_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] lvl_q;
  logic             full, do_wr, do_rd;

  assign full  = (lvl_q == LVL_W'(DEPTH));
  assign do_wr = wr_i && !full;
  assign do_rd = rd_valid_o && rd_ready_i;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      lvl_q      <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (do_wr) wptr_q <= wptr_q + PTR_W'(1);
      if (do_rd) rptr_q <= rptr_q + PTR_W'(1);
      lvl_q <= lvl_q + LVL_W'(do_wr) - LVL_W'(do_rd);
      if (wr_i && full)     overflow_o <= 1'b1;
      else if (ovf_clear_i) overflow_o <= 1'b0;
    end
  end

  assign rd_valid_o = (lvl_q != '0);
  assign rdata_o    = mem[rptr_q];
  assign level_o    = lvl_q;

  p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH));
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !ovf_clear_i) |=> overflow_o);
  p_ovf_on_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && full) |=> overflow_o);
  p_hold_under_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rdata_o)));
endmodule

// File: rtl/jtag_sniffer.sv
module jtag_sniffer
  import jsnf_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       jtag_tck,
  input  logic                       jtag_tms,
  input  logic                       jtag_tdi,
  input  logic                       jtag_tdo,
  input  logic                       ovf_clear,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic                       rd_is_ir,
  output logic [7:0]                 rd_tdi,
  output logic [7:0]                 rd_tdo,
  output logic [3:0]                 rd_nbits,
  output logic [$clog2(DEPTH+1)-1:0] fill_level,
  output logic                       overflow,
  output logic [3:0]                 tap_state
);
  logic [3:0] pins_s;
  logic       cap;
  tap_st_t    st;
  logic       rec_wr;
  cap_rec_t   rec_in, rec_out;
  logic [REC_W-1:0] rec_out_raw;

  jsnf_pin_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pins_i({jtag_tdo, jtag_tdi, jtag_tms, jtag_tck}),
    .pins_o(pins_s), .tck_rise_o(cap));

  jsnf_tap_tracker u_tap (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .tms_i(pins_s[1]), .state_o(st));

  jsnf_byte_packer u_pack (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .tms_i(pins_s[1]),
    .tdi_i(pins_s[2]), .tdo_i(pins_s[3]), .state_i(st),
    .wr_o(rec_wr), .rec_o(rec_in));

  jsnf_ring_buf #(.W(REC_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_i(rec_wr), .wdata_i(rec_in),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rdata_o(rec_out_raw),
    .level_o(fill_level), .ovf_clear_i(ovf_clear), .overflow_o(overflow));

  assign rec_out   = cap_rec_t'(rec_out_raw);
  assign rd_is_ir  = rec_out.is_ir;
  assign rd_tdi    = rec_out.tdi;
  assign rd_tdo    = rec_out.tdo;
  assign rd_nbits  = rec_out.nbits;
  assign tap_state = st;

  p_valid_matches_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (fill_level != '0));
endmodule

// File: tb/jtag_sniffer_tb_top.sv
module jtag_sniffer_tb_top;
  localparam int DEPTH = 16;
  localparam logic [3:0] S_TLR = 4'd0, S_RTI = 4'd1, S_SEL_DR = 4'd2, S_CAP_DR = 4'd3,
    S_SH_DR = 4'd4, S_EX1_DR = 4'd5, S_PA_DR = 4'd6, S_EX2_DR = 4'd7, S_UPD_DR = 4'd8,
    S_SEL_IR = 4'd9, S_CAP_IR = 4'd10, S_SH_IR = 4'd11, S_EX1_IR = 4'd12,
    S_PA_IR = 4'd13, S_EX2_IR = 4'd14, S_UPD_IR = 4'd15;

  // {tms, expected state after the capture}
  localparam int NWALK = 22;
  localparam logic [4:0] WALK [NWALK] = '{
    {1'b0, S_RTI},    {1'b1, S_SEL_DR}, {1'b0, S_CAP_DR}, {1'b0, S_SH_DR},
    {1'b1, S_EX1_DR}, {1'b0, S_PA_DR},  {1'b1, S_EX2_DR}, {1'b0, S_SH_DR},
    {1'b1, S_EX1_DR}, {1'b1, S_UPD_DR}, {1'b1, S_SEL_DR}, {1'b1, S_SEL_IR},
    {1'b0, S_CAP_IR}, {1'b0, S_SH_IR},  {1'b1, S_EX1_IR}, {1'b0, S_PA_IR},
    {1'b1, S_EX2_IR}, {1'b1, S_UPD_IR}, {1'b0, S_RTI},    {1'b1, S_SEL_DR},
    {1'b1, S_SEL_IR}, {1'b1, S_TLR}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic tck = 1'b0, tms = 1'b0, tdi = 1'b0, tdo = 1'b0;
  logic ovf_clear = 1'b0, rd_ready = 1'b0;
  logic rd_valid, rd_is_ir, overflow;
  logic [7:0] rd_tdi, rd_tdo;
  logic [3:0] rd_nbits, tap_state;
  logic [4:0] fill_level;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  jtag_sniffer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .jtag_tck(tck), .jtag_tms(tms), .jtag_tdi(tdi),
    .jtag_tdo(tdo), .ovf_clear(ovf_clear), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_is_ir(rd_is_ir), .rd_tdi(rd_tdi), .rd_tdo(rd_tdo), .rd_nbits(rd_nbits),
    .fill_level(fill_level), .overflow(overflow), .tap_state(tap_state));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tck_cycle(input logic m, input logic di, input logic dout);
    @(negedge clk);
    tms = m; tdi = di; tdo = dout; tck = 1'b0;
    repeat (6) @(negedge clk);
    tck = 1'b1;
    repeat (6) @(negedge clk);
    tck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pop_expect(input string req, input logic ir, input logic [7:0] ei,
                            input logic [7:0] eo, input logic [3:0] nb);
    @(negedge clk);
    chk({req, " valid"}, int'(rd_valid), 1);
    chk({req, " is_ir"}, int'(rd_is_ir), int'(ir));
    chk({req, " tdi"},   int'(rd_tdi), int'(ei));
    chk({req, " tdo"},   int'(rd_tdo), int'(eo));
    chk({req, " nbits"}, int'(rd_nbits), int'(nb));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic shift_bits(input logic [7:0] vi, input logic [7:0] vo,
                            input int n, input logic exit_last);
    for (int i = 0; i < n; i++)
      tck_cycle(exit_last && (i == n-1), vi[i], vo[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 reset state
    chk("R2 state", int'(tap_state), int'(S_TLR));
    chk("R2 valid", int'(rd_valid), 0);
    chk("R2 fill", int'(fill_level), 0);
    chk("R2 ovf", int'(overflow), 0);

    // R3 graph walk from the table
    for (int k = 0; k < NWALK; k++) begin
      tck_cycle(WALK[k][4], 1'b0, 1'b0);
      chk($sformatf("R3 walk step %0d", k), int'(tap_state), int'(WALK[k][3:0]));
    end
    // R6 one-bit flushes from each shift exit in the walk
    chk("R6 walk records", int'(fill_level), 3);
    pop_expect("R6 walk dr a", 1'b0, 8'h00, 8'h00, 4'd1);
    pop_expect("R6 walk dr b", 1'b0, 8'h00, 8'h00, 4'd1);
    pop_expect("R6 walk ir",   1'b1, 8'h00, 8'h00, 4'd1);
    chk("R8 drained", int'(rd_valid), 0);

    // R1 mode-select toggles with the test clock held low
    @(negedge clk); tms = 1'b1;
    repeat (10) @(negedge clk); tms = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1 no capture without edge", int'(tap_state), int'(S_TLR));

    // R5 full DR byte then R6 partial flush
    tck_cycle(0, 0, 0); tck_cycle(1, 0, 0); tck_cycle(0, 0, 0); tck_cycle(0, 0, 0);
    chk("R3 in shift-dr", int'(tap_state), int'(S_SH_DR));
    shift_bits(8'hA5, 8'h3C, 8, 1'b0);
    chk("R5 one record", int'(fill_level), 1);
    shift_bits(8'h05, 8'h06, 3, 1'b1);
    chk("R6 exit1-dr", int'(tap_state), int'(S_EX1_DR));
    chk("R8 no pop under backpressure", int'(fill_level), 2);
    // to shift-IR, five bits
    tck_cycle(1, 0, 0); tck_cycle(1, 0, 0); tck_cycle(1, 0, 0);
    tck_cycle(0, 0, 0); tck_cycle(0, 0, 0);
    chk("R3 in shift-ir", int'(tap_state), int'(S_SH_IR));
    shift_bits(8'h15, 8'h0A, 5, 1'b1);
    // R7 pause, toggling data, back to shift
    tck_cycle(0, 1, 1);
    chk("R3 pause-ir", int'(tap_state), int'(S_PA_IR));
    tck_cycle(0, 1, 1);
    chk("R6 no record in pause", int'(fill_level), 3);
    tck_cycle(1, 1, 1); tck_cycle(0, 1, 1);
    chk("R7 back in shift-ir", int'(tap_state), int'(S_SH_IR));
    shift_bits(8'h03, 8'h00, 2, 1'b1);
    chk("R7 records", int'(fill_level), 4);
    pop_expect("R5 full byte", 1'b0, 8'hA5, 8'h3C, 4'd8);
    pop_expect("R6 partial dr", 1'b0, 8'h05, 8'h06, 4'd3);
    pop_expect("R6 partial ir", 1'b1, 8'h15, 8'h0A, 4'd5);
    pop_expect("R7 fresh byte", 1'b1, 8'h03, 8'h00, 4'd2);

    // R4 five high captures from exit1-IR
    for (int k = 0; k < 5; k++) tck_cycle(1, 0, 0);
    chk("R4 reset by five ones", int'(tap_state), int'(S_TLR));

    // R9 overflow: 17 full bytes into a 16-deep buffer
    tck_cycle(0, 0, 0); tck_cycle(1, 0, 0); tck_cycle(0, 0, 0); tck_cycle(0, 0, 0);
    for (int b = 0; b < DEPTH + 1; b++) shift_bits(8'(b), ~8'(b), 8, 1'b0);
    chk("R9 fill full", int'(fill_level), DEPTH);
    chk("R9 ovf set", int'(overflow), 1);
    pop_expect("R9 oldest kept", 1'b0, 8'h00, 8'hFF, 4'd8);
    chk("R9 ovf sticky", int'(overflow), 1);
    @(negedge clk); ovf_clear = 1'b1;
    @(negedge clk); ovf_clear = 1'b0;
    chk("R9 ovf cleared", int'(overflow), 0);
    for (int b = 1; b < DEPTH - 1; b++) pop_expect("R9 order", 1'b0, 8'(b), ~8'(b), 4'd8);
    pop_expect("R9 last kept", 1'b0, 8'(DEPTH-1), ~8'(DEPTH-1), 4'd8);
    chk("R9 dropped entry absent", int'(rd_valid), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule